// File: doc/BRIEF.md
# Boundary-Scan Test Access Port Controller

This block is the test access port of a chip: a sixteen-state controller clocked by the test clock and steered by the mode-select pin, a 5-bit instruction register, a one-bit bypass register and a 32-bit identification register. The active instruction is decoded into a data-register selection and into pin-control outputs. Those outputs tell the surrounding pad ring to tri-state its pins, or to drive them from the boundary-scan cells. They also enable the internal scan chain or the memory self-test chain. Serial test data leaves on a single output that is only driven while a register is being shifted.

The boundary-scan cells, the internal scan chain and the memory self-test engine sit outside the block. They share the serial data input. They receive the selects and the capture, shift and update strobes, and they return their serial outputs to the block, which routes them to the data output. Two resets exist: a power-on reset input (active high) and the active-low test reset pin. Either one puts the controller into its reset state. Both are sampled on the rising test-clock edge.

Top module: `tap_ctrl`

## Requirements
- R1: While `por_rst` is high, or while the controller sits in Test-Logic-Reset (`tap_state`=0), the rising edge sets `instr` to the identification opcode 01100. Holding `tms` high for five rising edges reaches state 0 from any state, and state 0 holds while `tms` stays high.
- R2: `tap_state` follows the standard sixteen-state graph on each rising `tck`, with encoding 0 Test-Logic-Reset, 1 Run-Test/Idle, 2 Select-DR, 3 Capture-DR, 4 Shift-DR, 5 Exit1-DR, 6 Pause-DR, 7 Exit2-DR, 8 Update-DR, 9 Select-IR, 10 Capture-IR, 11 Shift-IR, 12 Exit1-IR, 13 Pause-IR, 14 Exit2-IR, 15 Update-IR.
- R3: Capture-IR loads 00001 into the instruction shift stage. That stage shifts out least significant bit first, with `tdi` entering at the top. `instr` changes only on the edge that leaves Update-IR.
- R4: The opcodes decode as follows. 00000 selects boundary scan and sets `pin_from_bsr`. 00001 selects boundary scan only. 00010 sets `sel_iscan`. 00100 selects bypass and sets `pin_from_bsr`. 00101 selects bypass and sets `pin_hiz`. 01010 sets `sel_mbist`. 01100 selects the identification register. 11111 selects bypass.
- R5: Every other 5-bit code behaves exactly like 11111: bypass is selected and all five select and pin-control outputs are low.
- R6: With bypass selected, Capture-DR clears the single bypass bit and each Shift-DR edge moves `tdi` into it, so `tdo` repeats `tdi` one shift later, starting with a 0.
- R7: With the identification opcode active, Capture-DR loads the 32-bit `ID_VALUE` with bit 0 forced to 1, and Shift-DR presents it on `tdo` least significant bit first.
- R8: `tdo` and `tdo_oe` change on the falling `tck` edge. `tdo_oe` is high exactly when `tap_state` is 4 or 11, and `tdo` is 0 while `tdo_oe` is low.
- R9: In Shift-DR with boundary scan, internal scan or memory self-test selected, `tdo` carries `bsr_so`, `iscan_so` or `mbist_so` respectively, as sampled at the falling edge. `dr_capture`, `dr_shift` and `dr_update` are high in states 3, 4 and 8.
- R10: `trst_n` low at a rising edge forces state 0 and opcode 01100 at that edge, from any state, including while shifting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| por_rst | input | 1 | Power-on reset, active high |
| trst_n | input | 1 | Test reset, active low |
| tms | input | 1 | Mode select |
| tdi | input | 1 | Serial data in, shared with external chains |
| bsr_so | input | 1 | Boundary-scan chain serial output |
| iscan_so | input | 1 | Internal scan chain serial output |
| mbist_so | input | 1 | Memory self-test chain serial output |
| tdo | output | 1 | Serial data out, updated on falling edge |
| tdo_oe | output | 1 | Output enable for `tdo` |
| tap_state | output | 4 | Controller state (R2 encoding) |
| instr | output | 5 | Active instruction |
| dr_capture | output | 1 | Capture-DR strobe for external chains |
| dr_shift | output | 1 | Shift-DR strobe for external chains |
| dr_update | output | 1 | Update-DR strobe for external chains |
| sel_bsr | output | 1 | Boundary-scan chain selected |
| sel_iscan | output | 1 | Internal scan selected and enabled |
| sel_mbist | output | 1 | Memory self-test selected and enabled |
| pin_from_bsr | output | 1 | Pins driven from boundary-scan cells |
| pin_hiz | output | 1 | All functional pins tri-stated |

## Verification
Two functions can land on the same edge. The test reset can arrive while a data register is mid-shift, and the edge leaving Update-IR both commits a new opcode and redirects the data path that the very next scan uses. The bench drops `trst_n` during Shift-DR and expects state 0, the identification opcode and a released `tdo_oe` from that single edge. It also loads random opcodes and scans right after each Update-IR. Each scan's output stream is judged against the register that the bench's own decode function picks for that opcode.

// File: rtl/tap_pkg.sv
`timescale 1ns/1ps
package tap_pkg;
  localparam int IR_W = 5;

  typedef enum logic [3:0] {
    ST_RESET    = 4'd0,  ST_IDLE     = 4'd1,  ST_DR_SEL   = 4'd2,  ST_DR_CAP   = 4'd3,
    ST_DR_SHIFT = 4'd4,  ST_DR_EXIT1 = 4'd5,  ST_DR_PAUSE = 4'd6,  ST_DR_EXIT2 = 4'd7,
    ST_DR_UPD   = 4'd8,  ST_IR_SEL   = 4'd9,  ST_IR_CAP   = 4'd10, ST_IR_SHIFT = 4'd11,
    ST_IR_EXIT1 = 4'd12, ST_IR_PAUSE = 4'd13, ST_IR_EXIT2 = 4'd14, ST_IR_UPD   = 4'd15
  } tap_state_e;

  localparam logic [IR_W-1:0] OP_EXTEST = 5'b00000;
  localparam logic [IR_W-1:0] OP_SAMPLE = 5'b00001;
  localparam logic [IR_W-1:0] OP_ISCAN  = 5'b00010;
  localparam logic [IR_W-1:0] OP_CLAMP  = 5'b00100;
  localparam logic [IR_W-1:0] OP_HIGHZ  = 5'b00101;
  localparam logic [IR_W-1:0] OP_MBIST  = 5'b01010;
  localparam logic [IR_W-1:0] OP_IDENT  = 5'b01100;
  localparam logic [IR_W-1:0] OP_BYPASS = 5'b11111;
  localparam logic [IR_W-1:0] IR_CAPTURE_VAL = 5'b00001;

  typedef struct packed {
    logic bsr;
    logic iscan;
    logic mbist;
    logic id;
    logic byp;
    logic drive;
    logic hiz;
  } dec_t;

  function automatic dec_t decode_op(input logic [IR_W-1:0] op);
    dec_t d;
    d = '0;
    case (op)
      OP_EXTEST: begin d.bsr = 1'b1; d.drive = 1'b1; end
      OP_SAMPLE: d.bsr = 1'b1;
      OP_ISCAN:  d.iscan = 1'b1;
      OP_CLAMP:  begin d.byp = 1'b1; d.drive = 1'b1; end
      OP_HIGHZ:  begin d.byp = 1'b1; d.hiz = 1'b1; end
      OP_MBIST:  d.mbist = 1'b1;
      OP_IDENT:  d.id = 1'b1;
      default:   d.byp = 1'b1;
    endcase
    return d;
  endfunction
endpackage

// File: rtl/tap_fsm.sv
`timescale 1ns/1ps
module tap_fsm
  import tap_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       tms,
  output tap_state_e state
);
  tap_state_e nxt;

  always_comb begin
    case (state)
      ST_RESET:    nxt = tms ? ST_RESET    : ST_IDLE;
      ST_IDLE:     nxt = tms ? ST_DR_SEL   : ST_IDLE;
      ST_DR_SEL:   nxt = tms ? ST_IR_SEL   : ST_DR_CAP;
      ST_DR_CAP:   nxt = tms ? ST_DR_EXIT1 : ST_DR_SHIFT;
      ST_DR_SHIFT: nxt = tms ? ST_DR_EXIT1 : ST_DR_SHIFT;
      ST_DR_EXIT1: nxt = tms ? ST_DR_UPD   : ST_DR_PAUSE;
      ST_DR_PAUSE: nxt = tms ? ST_DR_EXIT2 : ST_DR_PAUSE;
      ST_DR_EXIT2: nxt = tms ? ST_DR_UPD   : ST_DR_SHIFT;
      ST_DR_UPD:   nxt = tms ? ST_DR_SEL   : ST_IDLE;
      ST_IR_SEL:   nxt = tms ? ST_RESET    : ST_IR_CAP;
      ST_IR_CAP:   nxt = tms ? ST_IR_EXIT1 : ST_IR_SHIFT;
      ST_IR_SHIFT: nxt = tms ? ST_IR_EXIT1 : ST_IR_SHIFT;
      ST_IR_EXIT1: nxt = tms ? ST_IR_UPD   : ST_IR_PAUSE;
      ST_IR_PAUSE: nxt = tms ? ST_IR_EXIT2 : ST_IR_PAUSE;
      ST_IR_EXIT2: nxt = tms ? ST_IR_UPD   : ST_IR_SHIFT;
      default:     nxt = tms ? ST_DR_SEL   : ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_RESET;
    else     state <= nxt;
  end

  // R10: either reset lands in Test-Logic-Reset
  p_reset_lands_r10: assert property (@(posedge clk) rst |=> state == ST_RESET);
  // R1: TMS high keeps the reset state
  p_reset_holds_r1: assert property (@(posedge clk) disable iff (rst)
    (state == ST_RESET && tms) |=> state == ST_RESET);
  // R2: shift states hold while TMS is low
  p_shift_holds_r2: assert property (@(posedge clk) disable iff (rst)
    ((state == ST_DR_SHIFT || state == ST_IR_SHIFT) && !tms) |=> $stable(state));
endmodule

// File: rtl/tap_ir.sv
`timescale 1ns/1ps
module tap_ir
  import tap_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  tap_state_e      state,
  input  logic            tdi,
  output logic [IR_W-1:0] instr,
  output logic            ir_so,
  output dec_t            dec
);
  logic [IR_W-1:0] ir_sr;

  always_ff @(posedge clk) begin
    if (rst) begin
      ir_sr <= IR_CAPTURE_VAL;
      instr <= OP_IDENT;
      dec   <= decode_op(OP_IDENT);
    end else begin
      case (state)
        ST_IR_CAP:   ir_sr <= IR_CAPTURE_VAL;
        ST_IR_SHIFT: ir_sr <= {tdi, ir_sr[IR_W-1:1]};
        default:     ir_sr <= ir_sr;
      endcase
      if (state == ST_RESET) begin
        instr <= OP_IDENT;
        dec   <= decode_op(OP_IDENT);
      end else if (state == ST_IR_UPD) begin
        instr <= ir_sr;
        dec   <= decode_op(ir_sr);
      end
    end
  end

  assign ir_so = ir_sr[0];

  // R3: capture pattern appears after Capture-IR
  p_ir_capture_r3: assert property (@(posedge clk) disable iff (rst)
    state == ST_IR_CAP |=> ir_sr == IR_CAPTURE_VAL);
  // R3: active instruction moves only on update or reset state
  p_instr_stable_r3: assert property (@(posedge clk) disable iff (rst)
    (state != ST_IR_UPD && state != ST_RESET) |=> $stable(instr));
  // R4: at most one data register selected, never tri-state with drive
  p_one_select_r4: assert property (@(posedge clk) disable iff (rst)
    $onehot0({dec.bsr, dec.iscan, dec.mbist, dec.id, dec.byp}) && !(dec.hiz && dec.drive));
endmodule

// File: rtl/tap_dr.sv
`timescale 1ns/1ps
module tap_dr
  import tap_pkg::*;
#(
  parameter int             ID_W     = 32,
  parameter logic [ID_W-1:0] ID_VALUE = 32'h1B3C_A0F5
)(
  input  logic       clk,
  input  logic       rst,
  input  tap_state_e state,
  input  logic       tdi,
  input  logic       sel_byp,
  input  logic       sel_id,
  output logic       byp_q,
  output logic       id_so
);
  localparam logic [ID_W-1:0] ID_LOAD = {ID_VALUE[ID_W-1:1], 1'b1};
  logic [ID_W-1:0] id_sr;

  always_ff @(posedge clk) begin
    if (rst) begin
      byp_q <= 1'b0;
      id_sr <= ID_LOAD;
    end else begin
      if (sel_byp) begin
        if (state == ST_DR_CAP)        byp_q <= 1'b0;
        else if (state == ST_DR_SHIFT) byp_q <= tdi;
      end
      if (sel_id) begin
        if (state == ST_DR_CAP)        id_sr <= ID_LOAD;
        else if (state == ST_DR_SHIFT) id_sr <= {tdi, id_sr[ID_W-1:1]};
      end
    end
  end

  assign id_so = id_sr[0];

  // R6: bypass bit cleared by capture
  p_bypass_clear_r6: assert property (@(posedge clk) disable iff (rst)
    (state == ST_DR_CAP && sel_byp) |=> !byp_q);
  // R6: bypass bit follows the data input while shifting
  p_bypass_follow_r6: assert property (@(posedge clk) disable iff (rst)
    (state == ST_DR_SHIFT && sel_byp) |=> byp_q == $past(tdi));
  // R7: capture presents identification bit 0 which is always 1
  p_id_lsb_r7: assert property (@(posedge clk) disable iff (rst)
    (state == ST_DR_CAP && sel_id) |=> id_so);
endmodule

// File: rtl/tap_ctrl.sv
`timescale 1ns/1ps
module tap_ctrl
  import tap_pkg::*;
#(
  parameter int              ID_W     = 32,
  parameter logic [ID_W-1:0] ID_VALUE = 32'h1B3C_A0F5
)(
  input  logic       tck,
  input  logic       por_rst,
  input  logic       trst_n,
  input  logic       tms,
  input  logic       tdi,
  input  logic       bsr_so,
  input  logic       iscan_so,
  input  logic       mbist_so,
  output logic       tdo,
  output logic       tdo_oe,
  output logic [3:0] tap_state,
  output logic [4:0] instr,
  output logic       dr_capture,
  output logic       dr_shift,
  output logic       dr_update,
  output logic       sel_bsr,
  output logic       sel_iscan,
  output logic       sel_mbist,
  output logic       pin_from_bsr,
  output logic       pin_hiz
);
  logic       rst_i;
  tap_state_e state;
  dec_t       dec;
  logic       ir_so, byp_q, id_so, tdo_d, shifting;

  assign rst_i = por_rst | ~trst_n;

  tap_fsm u_fsm (.clk(tck), .rst(rst_i), .tms(tms), .state(state));

  tap_ir u_ir (.clk(tck), .rst(rst_i), .state(state), .tdi(tdi),
               .instr(instr), .ir_so(ir_so), .dec(dec));

  tap_dr #(.ID_W(ID_W), .ID_VALUE(ID_VALUE)) u_dr (
    .clk(tck), .rst(rst_i), .state(state), .tdi(tdi),
    .sel_byp(dec.byp), .sel_id(dec.id), .byp_q(byp_q), .id_so(id_so));

  assign shifting = (state == ST_DR_SHIFT) || (state == ST_IR_SHIFT);

  always_comb begin
    tdo_d = 1'b0;
    if (state == ST_IR_SHIFT)      tdo_d = ir_so;
    else if (state == ST_DR_SHIFT) begin
      if (dec.bsr)        tdo_d = bsr_so;
      else if (dec.iscan) tdo_d = iscan_so;
      else if (dec.mbist) tdo_d = mbist_so;
      else if (dec.id)    tdo_d = id_so;
      else                tdo_d = byp_q;
    end
  end

  always_ff @(negedge tck) begin
    if (rst_i) begin
      tdo    <= 1'b0;
      tdo_oe <= 1'b0;
    end else begin
      tdo    <= tdo_d;
      tdo_oe <= shifting;
    end
  end

  assign tap_state    = state;
  assign dr_capture   = (state == ST_DR_CAP);
  assign dr_shift     = (state == ST_DR_SHIFT);
  assign dr_update    = (state == ST_DR_UPD);
  assign sel_bsr      = dec.bsr;
  assign sel_iscan    = dec.iscan;
  assign sel_mbist    = dec.mbist;
  assign pin_from_bsr = dec.drive;
  assign pin_hiz      = dec.hiz;

  // R8: enable seen at the rising edge matches the shift states
  p_oe_window_r8: assert property (@(posedge tck) disable iff (rst_i)
    tdo_oe == ((tap_state == 4'd4) || (tap_state == 4'd11)));
  // R8: data output quiet while not enabled
  p_tdo_quiet_r8: assert property (@(posedge tck) disable iff (rst_i)
    !tdo_oe |-> !tdo);
endmodule

// File: tb/tap_ctrl_bench.sv
`timescale 1ns/1ps
module tap_ctrl_bench;
  localparam logic [31:0] IDV = 32'h1B3C_A0F5;
  localparam logic [31:0] ID_EXP = {IDV[31:1], 1'b1};

  logic tck = 1'b0;
  logic por_rst, trst_n, tms, tdi, bsr_so, iscan_so, mbist_so;
  logic tdo, tdo_oe, dr_capture, dr_shift, dr_update;
  logic sel_bsr, sel_iscan, sel_mbist, pin_from_bsr, pin_hiz;
  logic [3:0] tap_state;
  logic [4:0] instr;

  int nchk = 0, nfail = 0;
  bit done = 0;
  logic [3:0] m_state;

  always #10 tck = ~tck;

  tap_ctrl #(.ID_W(32), .ID_VALUE(IDV)) u_tap_ctrl (
    .tck(tck), .por_rst(por_rst), .trst_n(trst_n), .tms(tms), .tdi(tdi),
    .bsr_so(bsr_so), .iscan_so(iscan_so), .mbist_so(mbist_so),
    .tdo(tdo), .tdo_oe(tdo_oe), .tap_state(tap_state), .instr(instr),
    .dr_capture(dr_capture), .dr_shift(dr_shift), .dr_update(dr_update),
    .sel_bsr(sel_bsr), .sel_iscan(sel_iscan), .sel_mbist(sel_mbist),
    .pin_from_bsr(pin_from_bsr), .pin_hiz(pin_hiz));

  function automatic logic [3:0] model_next(input logic [3:0] s, input logic t);
    case (s)
      4'd0:  return t ? 4'd0  : 4'd1;
      4'd1:  return t ? 4'd2  : 4'd1;
      4'd2:  return t ? 4'd9  : 4'd3;
      4'd3:  return t ? 4'd5  : 4'd4;
      4'd4:  return t ? 4'd5  : 4'd4;
      4'd5:  return t ? 4'd8  : 4'd6;
      4'd6:  return t ? 4'd7  : 4'd6;
      4'd7:  return t ? 4'd8  : 4'd4;
      4'd8:  return t ? 4'd2  : 4'd1;
      4'd9:  return t ? 4'd0  : 4'd10;
      4'd10: return t ? 4'd12 : 4'd11;
      4'd11: return t ? 4'd12 : 4'd11;
      4'd12: return t ? 4'd15 : 4'd13;
      4'd13: return t ? 4'd14 : 4'd13;
      4'd14: return t ? 4'd15 : 4'd11;
      default: return t ? 4'd2 : 4'd1;
    endcase
  endfunction

  // expected {sel_bsr, sel_iscan, sel_mbist, pin_from_bsr, pin_hiz}
  function automatic logic [4:0] exp_ctrl(input logic [4:0] op);
    case (op)
      5'b00000: return 5'b10010;
      5'b00001: return 5'b10000;
      5'b00010: return 5'b01000;
      5'b00100: return 5'b00010;
      5'b00101: return 5'b00001;
      5'b01010: return 5'b00100;
      default:  return 5'b00000;
    endcase
  endfunction

  // 0 bypass, 1 id, 2 boundary, 3 internal scan, 4 memory test
  function automatic int exp_path(input logic [4:0] op);
    case (op)
      5'b00000, 5'b00001: return 2;
      5'b00010: return 3;
      5'b01010: return 4;
      5'b01100: return 1;
      default:  return 0;
    endcase
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(input logic t, input logic d);
    tms = t; tdi = d;
    @(posedge tck);
    if (por_rst || !trst_n) m_state = 4'd0;
    else m_state = model_next(m_state, t);
    @(negedge tck); #1;
  endtask

  task automatic go_reset();
    for (int i = 0; i < 6; i++) step(1'b1, 1'b0);
    chk(tap_state == 4'd0 && instr == 5'b01100, "R1 tms reset", {tap_state, instr}, {4'd0, 5'b01100});
    step(1'b0, 1'b0);
  endtask

  task automatic load_ir(input logic [4:0] code);
    logic [4:0] cap;
    logic [4:0] prev;
    prev = instr;
    step(1'b1, 1'b0); step(1'b1, 1'b0); step(1'b0, 1'b0); step(1'b0, 1'b0);
    for (int k = 0; k < 5; k++) begin
      cap[k] = tdo;
      step(k == 4, code[k]);
    end
    chk(cap == 5'b00001, "R3 capture pattern", cap, 5'b00001);
    step(1'b1, 1'b0);
    chk(tap_state == 4'd15 && instr == prev, "R3 held until update", instr, prev);
    step(1'b0, 1'b0);
    chk(instr == code, "R3 instr after update", instr, code);
    chk({sel_bsr, sel_iscan, sel_mbist, pin_from_bsr, pin_hiz} == exp_ctrl(code),
        (exp_ctrl(code) == 0 && exp_path(code) == 0) ? "R5 bypass-like decode" : "R4 decode",
        {sel_bsr, sel_iscan, sel_mbist, pin_from_bsr, pin_hiz}, exp_ctrl(code));
  endtask

  task automatic scan_dr(input int n, input logic [63:0] din, output logic [63:0] dout);
    dout = '0;
    step(1'b1, 1'b0); step(1'b0, 1'b0);
    chk(dr_capture == 1'b1, "R9 capture strobe", dr_capture, 1);
    step(1'b0, 1'b0);
    chk(dr_shift && tdo_oe, "R8 oe in shift", {dr_shift, tdo_oe}, 2'b11);
    for (int k = 0; k < n; k++) begin
      dout[k] = tdo;
      step(k == n - 1, din[k]);
    end
    step(1'b1, 1'b0);
    chk(dr_update == 1'b1, "R9 update strobe", dr_update, 1);
    step(1'b0, 1'b0);
    chk(!tdo_oe && !tdo, "R8 quiet outside shift", {tdo_oe, tdo}, 0);
  endtask

  function automatic logic [63:0] exp_scan(input int path, input int n, input logic [63:0] din,
                                           input logic b, input logic s, input logic m);
    logic [63:0] e;
    e = '0;
    for (int k = 0; k < n; k++) begin
      case (path)
        0: e[k] = (k == 0) ? 1'b0 : din[k-1];
        1: e[k] = ID_EXP[k];
        2: e[k] = b;
        3: e[k] = s;
        default: e[k] = m;
      endcase
    end
    return e;
  endfunction

  initial begin
    #(20 * 150000);
    if (!done) begin
      nfail++; nchk++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end

  initial begin
    logic [63:0] din, dout, e;
    logic [4:0] code;
    void'($urandom(32'd4711));
    por_rst = 1'b1; trst_n = 1'b1; tms = 1'b0; tdi = 1'b0;
    bsr_so = 1'b0; iscan_so = 1'b0; mbist_so = 1'b0;
    m_state = 4'd0;
    repeat (3) @(posedge tck);
    @(negedge tck); #1;
    chk(tap_state == 4'd0 && instr == 5'b01100 && !tdo_oe, "R1 power-on reset",
        {tap_state, instr, tdo_oe}, {4'd0, 5'b01100, 1'b0});
    chk({sel_bsr, sel_iscan, sel_mbist, pin_from_bsr, pin_hiz} == 5'b0, "R1 reset controls",
        {sel_bsr, sel_iscan, sel_mbist, pin_from_bsr, pin_hiz}, 0);
    por_rst = 1'b0;
    step(1'b0, 1'b0);

    // R7: full identification readout straight after reset
    scan_dr(32, 64'h0, dout);
    chk(dout[31:0] == ID_EXP, "R7 id readout", dout[31:0], ID_EXP);

    // R6: bypass delay with a known pattern
    load_ir(5'b11111);
    din = 64'h0000_0000_0000_B5C3;
    scan_dr(16, din, dout);
    e = exp_scan(0, 16, din, 0, 0, 0);
    chk(dout == e, "R6 bypass delay", dout, e);

    // R4 / R5 directed opcodes
    load_ir(5'b00101);
    chk(pin_hiz && !pin_from_bsr, "R4 tri-state", {pin_hiz, pin_from_bsr}, 2'b10);
    din = 64'h5;
    scan_dr(4, din, dout);
    e = exp_scan(0, 4, din, 0, 0, 0);
    chk(dout == e, "R4 tri-state uses bypass", dout, e);
    load_ir(5'b00100);
    load_ir(5'b00000);
    bsr_so = 1'b1;
    scan_dr(6, 64'h0, dout);
    chk(dout == 64'h3F, "R9 boundary chain to tdo", dout, 64'h3F);
    load_ir(5'b00010);
    iscan_so = 1'b1; bsr_so = 1'b0;
    scan_dr(5, 64'h0, dout);
    chk(dout == 64'h1F, "R9 internal scan to tdo", dout, 64'h1F);
    load_ir(5'b01010);
    load_ir(5'b11010);
    load_ir(5'b00011);
    din = 64'hA;
    scan_dr(4, din, dout);
    e = exp_scan(0, 4, din, 0, 0, 0);
    chk(dout == e, "R5 unlisted code as bypass", dout, e);

    // R1: TMS reset brings back identification
    load_ir(5'b00101);
    go_reset();

    // R10: test reset during a shift
    load_ir(5'b00001);
    step(1'b1, 1'b0); step(1'b0, 1'b0); step(1'b0, 1'b0);
    trst_n = 1'b0;
    step(1'b0, 1'b1);
    chk(tap_state == 4'd0 && instr == 5'b01100 && !tdo_oe, "R10 trst in shift",
        {tap_state, instr, tdo_oe}, {4'd0, 5'b01100, 1'b0});
    trst_n = 1'b1;
    step(1'b0, 1'b0);

    // R2 / R8: random TMS walk against the model
    for (int i = 0; i < 400; i++) begin
      step(1'($urandom), 1'($urandom));
      chk(tap_state == m_state, "R2 state walk", tap_state, m_state);
      chk(tdo_oe == (m_state == 4'd4 || m_state == 4'd11), "R8 oe walk", tdo_oe,
          (m_state == 4'd4 || m_state == 4'd11));
    end
    go_reset();

    // random opcodes followed by scans
    for (int i = 0; i < 40; i++) begin
      code = 5'($urandom);
      if (i % 4 == 0) code = 5'b01100;
      load_ir(code);
      bsr_so = 1'($urandom); iscan_so = 1'($urandom); mbist_so = 1'($urandom);
      din = {32'h0, $urandom};
      scan_dr(8, din, dout);
      e = exp_scan(exp_path(code), 8, din, bsr_so, iscan_so, mbist_so);
      chk(dout == e, (exp_path(code) == 0) ? "R6 random bypass path" :
                     (exp_path(code) == 1) ? "R7 random id path" : "R9 random chain path",
          dout, e);
    end

    done = 1;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule